// File: doc/BRIEF.md
# CAN Controller Mode-Control Register

This block holds the module configuration word of a mailbox-based CAN controller. Through the word, software moves the controller between three operating modes. In disabled mode the module is switched off. In freeze mode it is enabled but held for configuration. In normal mode mailbox traffic may flow. The block reports the mode through read-only acknowledge and not-ready bits. These bits are always recomputed from the request bits in the same cycle, so no bus-idle delay is modelled.

Software reaches the block through a 32-bit register port. Address 0 is the mode word. The addresses after it are the controller's plain control registers. A soft-reset request written to the mode word restores a fixed configuration image and clears every control register.

The block drives mode outputs that gate the mailbox engine. It also brings out the receive-FIFO enable, the self-reception disable and the highest mailbox index.

Top module: `can_mode_ctrl`

## Requirements
- R1: After rst_n, address 0 reads 0x5980000F (default parameters), every control register reads 0 and freeze_o is 1.
- R2: While bit 31 (disable request) is 1, bit 20 (low-power acknowledge) reads 1, bit 27 (not-ready) reads 1 and bit 24 (freeze acknowledge) reads 0, whatever bits 30 (freeze enable) and 28 (halt) hold; 0xD890000F, 0xB890000F, 0xE890000F and 0xA890000F each read back unchanged.
- R3: With bit 31 at 0 and both bit 30 and bit 28 at 1, bits 24 and 27 read 1 and bit 20 reads 0; writing 0x5980000F or 0x7980000F reads back unchanged.
- R4: With bit 31 at 0 and either bit 30 or bit 28 at 0, bits 24, 27 and 20 all read 0; 0x3980000F reads 0x3080000F and 0x6980000F reads 0x6080000F.
- R5: Bits 27, 24 and 20 ignore write data and are derived only from the request bits.
- R6: A mode-word write with bit 25 (soft reset) at 1 discards the other write data, restores the reset image 0x5980000F and clears all control registers in every mode; bit 25 always reads 0.
- R7: Control register 1 (address 1) keeps bit 13 at 0, and writes to control registers never change the mode word.
- R8: run_o is 1 only when the module is enabled and freeze acknowledge is 0; freeze_o mirrors bit 24 and disabled_o mirrors bit 31.
- R9: Bits 26, 22, 21 and 19 down to MB_IDX_W of the mode word read 0, and address 3 reads 0.
- R10: A write takes effect at the next rising clk edge, and reads are combinational from addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register select: 0 mode word, k control register k |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| run_o | output | 1 | Mailbox engine may transmit and receive |
| freeze_o | output | 1 | Freeze acknowledged |
| disabled_o | output | 1 | Module disabled |
| rx_fifo_en_o | output | 1 | Receive FIFO enable request |
| self_rx_dis_o | output | 1 | Self-reception disable |
| max_mb_o | output | MB_IDX_W | Highest mailbox index in use |

## Verification
The hardest situations to reach from the ports are the ones where the stored request bits disagree with the acknowledge that software just wrote. One example is a disabled module whose halt or freeze-enable request is dropped. Another is a write that sets the status bits directly while all requests are clear. The stimulus writes these words one after another, so each transition starts from the state the previous word left. A soft reset is also issued while the module is disabled and the control registers hold nonzero data, which shows that the reset image wins over both.

// File: rtl/canmc_pkg.sv
package canmc_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned B_DIS   = 31;
   localparam int unsigned B_FRZEN = 30;
   localparam int unsigned B_FIFO  = 29;
   localparam int unsigned B_HALT  = 28;
   localparam int unsigned B_NRDY  = 27;
   localparam int unsigned B_SRST  = 25;
   localparam int unsigned B_FACK  = 24;
   localparam int unsigned B_SRXD  = 23;
   localparam int unsigned B_LPACK = 20;

   typedef struct packed {
      logic dis;
      logic frz_en;
      logic fifo_en;
      logic halt;
      logic srx_dis;
   } mode_req_t;

   typedef struct packed {
      logic frz_ack;
      logic not_rdy;
      logic lp_ack;
   } mode_stat_t;

   localparam mode_req_t REQ_IMAGE = '{dis: 1'b0, frz_en: 1'b1, fifo_en: 1'b0,
                                       halt: 1'b1, srx_dis: 1'b1};
endpackage

// File: rtl/canmc_req_reg.sv
module canmc_req_reg
   import canmc_pkg::*;
#(
   parameter int unsigned MB_IDX_W = 7,
   parameter int unsigned RESET_MB = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  logic [WORD_W-1:0]    wdata,
   output mode_req_t            req_o,
   output logic [MB_IDX_W-1:0]  max_mb_o,
   output logic                 srst_o
);
   localparam logic [MB_IDX_W-1:0] MB_IMAGE = MB_IDX_W'(RESET_MB);

   logic [WORD_W-1:0] unused_bits;
   assign unused_bits = wdata;

   assign srst_o = wr_stb & wdata[B_SRST];

   always_ff @(posedge clk) begin
      if (!rst_n || srst_o) begin
         req_o    <= REQ_IMAGE;
         max_mb_o <= MB_IMAGE;
      end else if (wr_stb) begin
         req_o.dis     <= wdata[B_DIS];
         req_o.frz_en  <= wdata[B_FRZEN];
         req_o.fifo_en <= wdata[B_FIFO];
         req_o.halt    <= wdata[B_HALT];
         req_o.srx_dis <= wdata[B_SRXD];
         max_mb_o      <= wdata[MB_IDX_W-1:0];
      end
   end
endmodule

// File: rtl/canmc_status.sv
module canmc_status
   import canmc_pkg::*;
(
   input  mode_req_t  req_i,
   output mode_stat_t stat_o
);
   always_comb begin
      stat_o.lp_ack  = req_i.dis;
      stat_o.frz_ack = !req_i.dis && req_i.frz_en && req_i.halt;
      stat_o.not_rdy = req_i.dis || (req_i.frz_en && req_i.halt);
   end
endmodule

// File: rtl/canmc_ctrl_bank.sv
module canmc_ctrl_bank
   import canmc_pkg::*;
#(
   parameter int unsigned NUM_CTRL = 2,
   parameter int unsigned ADDR_W   = 2,
   parameter logic [NUM_CTRL*WORD_W-1:0] WMASK = {32'hFFFF_FFFF, 32'hFFFF_DFFF}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [WORD_W-1:0]          wdata,
   input  logic                       clr,
   output logic [NUM_CTRL*WORD_W-1:0] ctrl_o
);
   for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k + 1);
      localparam logic [WORD_W-1:0] MASK    = WMASK[k*WORD_W +: WORD_W];
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            ctrl_o[k*WORD_W +: WORD_W] <= '0;
         else if (wr_en && addr == MY_ADDR)
            ctrl_o[k*WORD_W +: WORD_W] <= wdata & MASK;
      end
   end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import canmc_pkg::*;
#(
   parameter int unsigned MB_IDX_W = 7,
   parameter int unsigned RESET_MB = 15,
   parameter int unsigned NUM_CTRL = 2,
   parameter int unsigned ADDR_W   = 2,
   parameter logic [NUM_CTRL*32-1:0] CTRL_WMASK = {32'hFFFF_FFFF, 32'hFFFF_DFFF}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   output logic                 run_o,
   output logic                 freeze_o,
   output logic                 disabled_o,
   output logic                 rx_fifo_en_o,
   output logic                 self_rx_dis_o,
   output logic [MB_IDX_W-1:0]  max_mb_o
);
   localparam int unsigned NUM_REGS = NUM_CTRL + 1;

   if (MB_IDX_W < 1 || MB_IDX_W > 20) begin : g_bad_mbw
      $error("MB_IDX_W must lie in 1..20");
   end
   if (RESET_MB >= (1 << MB_IDX_W)) begin : g_bad_rmb
      $error("RESET_MB does not fit MB_IDX_W");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_aw
      $error("ADDR_W too narrow for NUM_CTRL");
   end

   mode_req_t              req;
   mode_stat_t             stat;
   logic                   srst;
   logic                   wr_mode;
   logic [WORD_W-1:0]      mode_word;
   logic [NUM_CTRL*WORD_W-1:0] ctrl_flat;

   assign wr_mode = wr_en && (addr == '0);

   canmc_req_reg #(.MB_IDX_W(MB_IDX_W), .RESET_MB(RESET_MB)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_mode),
      .wdata    (wdata),
      .req_o    (req),
      .max_mb_o (max_mb_o),
      .srst_o   (srst)
   );

   canmc_status u_stat (
      .req_i  (req),
      .stat_o (stat)
   );

   canmc_ctrl_bank #(.NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W), .WMASK(CTRL_WMASK)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .clr    (srst),
      .ctrl_o (ctrl_flat)
   );

   always_comb begin
      mode_word                 = '0;
      mode_word[B_DIS]          = req.dis;
      mode_word[B_FRZEN]        = req.frz_en;
      mode_word[B_FIFO]         = req.fifo_en;
      mode_word[B_HALT]         = req.halt;
      mode_word[B_NRDY]         = stat.not_rdy;
      mode_word[B_FACK]         = stat.frz_ack;
      mode_word[B_SRXD]         = req.srx_dis;
      mode_word[B_LPACK]        = stat.lp_ack;
      mode_word[MB_IDX_W-1:0]   = max_mb_o;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0)
         rdata = mode_word;
      for (int k = 0; k < NUM_CTRL; k++)
         if (addr == ADDR_W'(k + 1))
            rdata = ctrl_flat[k*WORD_W +: WORD_W];
   end

   assign disabled_o    = req.dis;
   assign freeze_o      = stat.frz_ack;
   assign run_o         = !req.dis && !stat.frz_ack;
   assign rx_fifo_en_o  = req.fifo_en;
   assign self_rx_dis_o = req.srx_dis;
endmodule

// File: rtl/canmc_checker.sv
module canmc_checker #(
   parameter int unsigned MB_IDX_W = 7,
   parameter int unsigned RESET_MB = 15,
   parameter int unsigned NUM_CTRL = 2,
   parameter int unsigned ADDR_W   = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       addr,
   input logic [31:0]             wdata,
   input logic [31:0]             mode_word,
   input logic [NUM_CTRL*32-1:0]  ctrl_flat,
   input logic                    run_o,
   input logic                    freeze_o,
   input logic                    disabled_o
);
   localparam logic [31:0] IMAGE = 32'h5980_0000 | 32'(RESET_MB);

   a_r2_disabled_status: assert property (@(posedge clk) disable iff (!rst_n)
      mode_word[31] |-> (mode_word[20] && mode_word[27] && !mode_word[24]));

   a_r3_freeze_nrdy: assert property (@(posedge clk) disable iff (!rst_n)
      mode_word[24] |-> (mode_word[27] && !mode_word[20]));

   a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0 && wdata[25]) |=> (mode_word == IMAGE && ctrl_flat == '0));

   a_r6_srst_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_word[25]);

   a_r7_ctrl_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != '0) |=> $stable(mode_word));

   a_r8_run_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({run_o, freeze_o, disabled_o}) && (run_o || freeze_o || disabled_o));

   a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_word[26] == 1'b0) && (mode_word[22:21] == 2'b00));
endmodule

bind can_mode_ctrl canmc_checker #(
   .MB_IDX_W(MB_IDX_W), .RESET_MB(RESET_MB), .NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .wdata      (wdata),
   .mode_word  (mode_word),
   .ctrl_flat  (ctrl_flat),
   .run_o      (run_o),
   .freeze_o   (freeze_o),
   .disabled_o (disabled_o)
);

// File: tb/can_mode_ctrl_tb.sv
`timescale 1ns/100ps
module can_mode_ctrl_tb;
   localparam real HALF = 2.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        run_o, freeze_o, disabled_o, rx_fifo_en_o, self_rx_dis_o;
   logic [6:0]  max_mb_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   always #(HALF) clk = ~clk;

   can_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .run_o(run_o), .freeze_o(freeze_o), .disabled_o(disabled_o),
      .rx_fifo_en_o(rx_fifo_en_o), .self_rx_dis_o(self_rx_dis_o), .max_mb_o(max_mb_o)
   );

   // behavioural reference model
   bit          m_dis, m_fe, m_fifo, m_halt, m_srx;
   int          m_mb;
   logic [31:0] m_c1, m_c2;

   task automatic m_image();
      m_dis = 0; m_fe = 1; m_fifo = 0; m_halt = 1; m_srx = 1; m_mb = 15;
      m_c1 = 0; m_c2 = 0;
   endtask

   function automatic logic [31:0] m_word();
      bit fack;
      logic [31:0] w;
      fack = !m_dis && m_fe && m_halt;
      w = 32'(m_mb);
      if (m_dis)  w |= 32'h8010_0000;
      if (m_fe)   w |= 32'h4000_0000;
      if (m_fifo) w |= 32'h2000_0000;
      if (m_halt) w |= 32'h1000_0000;
      if (m_dis || fack) w |= 32'h0800_0000;
      if (fack)   w |= 32'h0100_0000;
      if (m_srx)  w |= 32'h0080_0000;
      return w;
   endfunction

   function automatic logic [31:0] m_read(logic [1:0] a);
      case (a)
         2'd0: return m_word();
         2'd1: return m_c1;
         2'd2: return m_c2;
         default: return 32'h0;
      endcase
   endfunction

   initial m_image();

   always @(posedge clk) begin
      if (!rst_n) m_image();
      else if (wr_en) begin
         if (addr == 2'd0) begin
            if (wdata[25]) m_image();
            else begin
               m_dis = wdata[31]; m_fe = wdata[30]; m_fifo = wdata[29];
               m_halt = wdata[28]; m_srx = wdata[23]; m_mb = int'(wdata[6:0]);
            end
         end else if (addr == 2'd1) m_c1 = wdata & 32'hFFFF_DFFF;
         else if (addr == 2'd2) m_c2 = wdata;
      end
   end

   // every-clock comparison (R10 timing, R8 outputs)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] ew;
         bit fack;
         ew = m_word();
         fack = !m_dis && m_fe && m_halt;
         n_vec++;
         if (rdata !== m_read(addr) || run_o !== (!m_dis && !fack) ||
             freeze_o !== fack || disabled_o !== m_dis ||
             rx_fifo_en_o !== m_fifo || self_rx_dis_o !== m_srx ||
             max_mb_o !== 7'(m_mb)) begin
            n_bad++;
            $display("FAIL R10/R8 clock compare addr=%0d rdata=%h exp=%h run/frz/dis=%b%b%b exp=%b%b%b mode=%h",
                     addr, rdata, m_read(addr), run_o, freeze_o, disabled_o,
                     !m_dis && !fack, fack, m_dis, ew);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk); #1;
      wr_en = 0;
   endtask

   task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      addr = a;
      #0.5;
      n_vec++;
      if (rdata !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, exp);
      end
   endtask

   task automatic bit_check(input logic act, input logic exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   initial begin
      #(HALF * 2 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rd_check(0, 32'h5980_000F, "R1 mode reset");
      rd_check(1, 32'h0, "R1 ctrl1 reset");
      rd_check(2, 32'h0, "R1 ctrl2 reset");
      bit_check(freeze_o, 1'b1, "R1 freeze_o reset");
      // R2 disabled
      wr(0, 32'hD890_000F); rd_check(0, 32'hD890_000F, "R2 disable");
      bit_check(disabled_o, 1'b1, "R8 disabled_o");
      bit_check(run_o, 1'b0, "R8 run_o disabled");
      wr(0, 32'hB890_000F); rd_check(0, 32'hB890_000F, "R2 drop freeze enable");
      wr(0, 32'hF890_000F); wr(0, 32'hE890_000F); rd_check(0, 32'hE890_000F, "R2 drop halt");
      wr(0, 32'hF890_000F); wr(0, 32'hA890_000F); rd_check(0, 32'hA890_000F, "R2 drop both");
      // R7 reserved ctrl1 bit
      wr(1, 32'h0000_2000);
      rd_check(1, 32'h0, "R7 ctrl1 bit13");
      rd_check(0, 32'hA890_000F, "R7 mode untouched");
      // R3 freeze
      wr(0, 32'h5980_000F); rd_check(0, 32'h5980_000F, "R3 freeze enter");
      wr(0, 32'h7980_000F); rd_check(0, 32'h7980_000F, "R3 freeze fifo");
      // R4 leave freeze
      wr(0, 32'h3980_000F); rd_check(0, 32'h3080_000F, "R4 clear freeze enable");
      bit_check(run_o, 1'b1, "R8 run_o normal");
      bit_check(rx_fifo_en_o, 1'b1, "R8 fifo enable out");
      wr(0, 32'h7980_000F);
      wr(0, 32'h6980_000F); rd_check(0, 32'h6080_000F, "R4 clear halt");
      // R5 status bits ignore writes
      wr(0, 32'h0910_000F); rd_check(0, 32'h0000_000F, "R5 status set by write");
      wr(0, 32'h8000_0000); rd_check(0, 32'h8810_0000, "R5 status clear by write");
      // R9 unused bits
      wr(0, 32'hFDFF_FFFF); rd_check(0, 32'hF890_007F, "R9 unused bits");
      rd_check(3, 32'h0, "R9 address 3");
      // R6 soft reset
      wr(1, 32'h1234_5678); wr(2, 32'hCAFE_F00D);
      rd_check(1, 32'h1234_5678, "R6 ctrl1 loaded");
      rd_check(2, 32'hCAFE_F00D, "R6 ctrl2 loaded");
      wr(0, 32'h0200_0003);
      rd_check(0, 32'h5980_000F, "R6 soft reset image");
      rd_check(1, 32'h0, "R6 ctrl1 cleared");
      rd_check(2, 32'h0, "R6 ctrl2 cleared");
      wr(0, 32'hD890_000F); wr(2, 32'h0000_00FF);
      wr(0, 32'h8200_0000);
      rd_check(0, 32'h5980_000F, "R6 soft reset from disabled");
      rd_check(2, 32'h0, "R6 ctrl2 cleared from disabled");
      repeat (4) @(negedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule